// File: doc/BRIEF.md
# Serial Two-Wire Control Register Target

This block is a target-only two-wire serial (I2C-compatible) port that lets a host read and write a small bank of 8-bit control registers. It answers one 7-bit bus address, made of the fixed prefix `001000` and a least significant bit taken from a strap input, so two instances can share one bus. SCL is only an input and is never stretched. SDA is driven open-drain: the block outputs only an enable that pulls the line low.

In a write, the byte after the address loads an internal register pointer. Bit 7 of that byte turns on auto-increment and bits 6:0 select the register. Any further bytes are stored at the selected register. In a read, the block returns the register at the current pointer, MSB first, and keeps sending while the host acknowledges. A repeated START keeps the pointer, so a host can set the pointer with a short write and then read from that point. One register mirrors a status input, and two bits of another mirror flag inputs. These are visible to reads and cannot be changed by writes.

Both bus lines are sampled by the system clock through two-flop synchronizers. All START, STOP and SCL edge decisions are made on the synchronized copies.

Top module: `regbank_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal `001000` followed by the `strap_lsb` level. Bit 0 of the address byte selects the direction (1 = read, 0 = write).
- R2: After an address mismatch, SDA stays released until the next START, and no register changes, whatever bytes follow.
- R3: In a write, the first byte after the address loads the pointer (bit 7 = auto-increment enable, bits 6:0 = index). Each later byte is stored at the register the pointer selects, and the stored values appear on `regs_flat`, with register i in bits 8*i+7:8*i.
- R4: In a read, the block shifts out the byte of the register at the pointer, MSB first, with SDA driven low for 0 bits and released for 1 bits.
- R5: With auto-increment enabled, the index advances by one after each byte is written and each time a byte is fetched for a read. Index 7 wraps to 0. With auto-increment off, the index does not change.
- R6: The block pulls SDA low for the acknowledge bit after a matching address and after every byte it receives in a write.
- R7: Register 6 always reads `status_in`, and writes to it are ignored. Bits 7:6 of register 1 always read `flags_in[1:0]`, and writes to those bits are ignored. Bits 5:0 of register 1 can be written.
- R8: A NACK from the host after a read byte, or a STOP at any time, releases SDA and returns the block to idle.
- R9: A repeated START restarts address decoding and keeps the pointer from the earlier transfer.
- R10: SDA output changes only while the synchronized SCL is low.
- R11: An index of 8 or more reads as 0x00, and writes to such an index are ignored.
- R12: After reset all writable register bits are 0, the pointer is 0 with auto-increment off, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_lsb | input | 1 | Sets bit 0 of the 7-bit bus address |
| status_in | input | 8 | Value shown at read-only register 6 |
| flags_in | input | 2 | Values shown at bits 7:6 of register 1 |
| regs_flat | output | 64 | Readable contents of all registers, register i in bits 8*i+7:8*i |

## Verification
On every cycle, the assertions check these properties: SDA never changes while SCL is high; the line is released whenever the block is idle, including after a mismatch or a NACK; the acknowledge states hold SDA low; a STOP returns the block to idle; and the pointer moves only on an SCL falling edge. The bench's scenarios show the rest: address matching with both strap levels, the values written and read back, auto-increment across the 7-to-0 wrap, masking of the read-only bits, out-of-range indices, and a pointer kept across a repeated START. These cannot be checked without a model of the register contents.

// File: rtl/i2crb_pkg.sv
package i2crb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_RX,
    S_RXACK,
    S_TX,
    S_TXACK,
    S_TXNEXT
  } st_t;

  localparam logic [5:0] ADDR_PREFIX = 6'b001000;
endpackage

// File: rtl/i2crb_line_sync.sv
module i2crb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2crb_regs.sv
module i2crb_regs #(
  parameter int NREG     = 8,
  parameter int STAT_IDX = 6,
  parameter int RO_IDX   = 1,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [6:0]        widx,
  input  logic [7:0]        wdata,
  input  logic [6:0]        ridx,
  input  logic [7:0]        status_in,
  input  logic [1:0]        flags_in,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] view [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == STAT_IDX) begin : g_stat
      assign view[i] = status_in;
    end else if (i == RO_IDX) begin : g_mixed
      logic [5:0] q;
      logic       en;
      assign en = we && (widx == 7'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wdata[5:0];
      end
      assign view[i] = {flags_in, q};
    end else begin : g_rw
      logic [7:0] q;
      logic       en;
      assign en = we && (widx == 7'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wdata;
      end
      assign view[i] = q;
    end
    assign regs_flat[i*8 +: 8] = view[i];
  end

  assign rdata = (ridx < 7'(NREG)) ? view[ridx[IDX_W-1:0]] : 8'h00;
endmodule

// File: rtl/i2crb_proto.sv
module i2crb_proto
  import i2crb_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       strap_lsb,
  input  logic [7:0] rdata,
  output logic       sda_oe,
  output logic       we,
  output logic [7:0] wdata,
  output logic [6:0] ptr_idx,
  output st_t        state
);
  st_t        st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sr_q, sr_d;
  logic       rw_q, rw_d, have_q, have_d, auto_q, auto_d, oe_q, oe_d;
  logic [6:0] idx_q, idx_d, idx_adv;
  logic       do_load;

  assign idx_adv = (idx_q == 7'(NREG-1)) ? 7'd0 : idx_q + 7'd1;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sr_d = sr_q; rw_d = rw_q; have_d = have_q;
    auto_d = auto_q; idx_d = idx_q; oe_d = oe_q;
    we = 1'b0; do_load = 1'b0;
    if (stop_det) begin
      st_d = S_IDLE; oe_d = 1'b0;
    end else if (start_det) begin
      st_d = S_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: ;
        S_ADDR: begin
          if (scl_rise) begin
            sr_d = {sr_q[6:0], sda_s}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sr_q[7:1] == {ADDR_PREFIX, strap_lsb}) begin
              rw_d = sr_q[0]; oe_d = 1'b1; st_d = S_AACK;
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (rw_q) do_load = 1'b1;
          else begin
            oe_d = 1'b0; cnt_d = '0; have_d = 1'b0; st_d = S_RX;
          end
        end
        S_RX: begin
          if (scl_rise) begin
            sr_d = {sr_q[6:0], sda_s}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            oe_d = 1'b1; st_d = S_RXACK;
            if (!have_q) begin
              auto_d = sr_q[7]; idx_d = sr_q[6:0]; have_d = 1'b1;
            end else begin
              we = 1'b1;
              if (auto_q) idx_d = idx_adv;
            end
          end
        end
        S_RXACK: if (scl_fall) begin
          oe_d = 1'b0; cnt_d = '0; st_d = S_RX;
        end
        S_TX: begin
          if (scl_rise) cnt_d = cnt_q + 4'd1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d = 1'b0; st_d = S_TXACK;
            end else begin
              sr_d = {sr_q[6:0], 1'b0}; oe_d = ~sr_q[6];
            end
          end
        end
        S_TXACK: if (scl_rise) st_d = sda_s ? S_IDLE : S_TXNEXT;
        S_TXNEXT: if (scl_fall) do_load = 1'b1;
        default: st_d = S_IDLE;
      endcase
      if (do_load) begin
        sr_d = rdata; oe_d = ~rdata[7]; cnt_d = '0; st_d = S_TX;
        if (auto_q) idx_d = idx_adv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; sr_q <= '0; rw_q <= 1'b0; have_q <= 1'b0;
      auto_q <= 1'b0; idx_q <= '0; oe_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sr_q <= sr_d; rw_q <= rw_d; have_q <= have_d;
      auto_q <= auto_d; idx_q <= idx_d; oe_q <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wdata   = sr_q;
  assign ptr_idx = idx_q;
  assign state   = st_q;
endmodule

// File: rtl/regbank_i2c_target.sv
module regbank_i2c_target
  import i2crb_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int STAT_IDX    = 6,
  parameter int RO_IDX      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              strap_lsb,
  input  logic [7:0]        status_in,
  input  logic [1:0]        flags_in,
  output logic [NREG*8-1:0] regs_flat
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic we;
  logic [7:0] wdata, rdata;
  logic [6:0] ptr_idx;
  st_t fsm_state;

  i2crb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2crb_proto #(.NREG(NREG)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap_lsb(strap_lsb), .rdata(rdata), .sda_oe(sda_oe), .we(we),
    .wdata(wdata), .ptr_idx(ptr_idx), .state(fsm_state)
  );

  i2crb_regs #(.NREG(NREG), .STAT_IDX(STAT_IDX), .RO_IDX(RO_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(ptr_idx), .wdata(wdata),
    .ridx(ptr_idx), .status_in(status_in), .flags_in(flags_in),
    .rdata(rdata), .regs_flat(regs_flat)
  );
endmodule

// File: rtl/regbank_i2c_target_chk.sv
module regbank_i2c_target_chk
  import i2crb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       stop_det,
  input logic       sda_oe,
  input logic [6:0] ptr_idx,
  input st_t        state
);
  // R10: the data line only moves while the clock line is low
  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R8: a STOP leaves the block idle with the line released
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == S_IDLE && !sda_oe));

  // R2: idle (also after a mismatch or NACK) never pulls the line
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  // R6: acknowledge phases hold the line low
  a_r6_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_AACK || state == S_RXACK) |-> sda_oe);

  // R5: the pointer moves only on a falling clock edge
  a_r5_ptr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_idx) |-> $past(scl_fall));
endmodule

bind regbank_i2c_target regbank_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .stop_det(stop_det), .sda_oe(sda_oe), .ptr_idx(ptr_idx), .state(fsm_state)
);

// File: tb/test_regbank_i2c_target.sv
module test_regbank_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [7:0] STAT  = 8'hA5;
  localparam logic [1:0] FLAGS = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic strap = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [63:0] regs_flat;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] mdl [8];
  logic       m_auto;
  logic [6:0] m_idx;
  logic [7:0] wbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  regbank_i2c_target i_regbank_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_lsb(strap), .status_in(STAT), .flags_in(FLAGS), .regs_flat(regs_flat)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [6:0] i);
    if (i >= 7'd8) return 8'h00;
    if (i == 7'd6) return STAT;
    if (i == 7'd1) return {FLAGS, mdl[1][5:0]};
    return mdl[i[2:0]];
  endfunction

  function automatic logic [63:0] exp_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = exp_rd(7'(i));
    return f;
  endfunction

  task automatic mwrite(input logic [6:0] i, input logic [7:0] v);
    if (i < 7'd8 && i != 7'd6) mdl[i[2:0]] = (i == 7'd1) ? {2'b00, v[5:0]} : v;
  endtask

  task automatic madv();
    if (m_auto) m_idx = (m_idx == 7'd7) ? 7'd0 : m_idx + 7'd1;
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(1); m_scl = 1'b1; wq(1); m_low = 1'b1; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(1); m_scl = 1'b1; wq(1); m_low = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(1); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(1);
    end
    m_low = 1'b0; wq(1); m_scl = 1'b1; wq(1); ack = ~sda_bus; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      m_low = 1'b0; wq(1); m_scl = 1'b1; wq(1); b = {b[6:0], sda_bus}; wq(1);
      m_scl = 1'b0; wq(1);
    end
    m_low = give_ack; wq(1); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(1);
    m_low = 1'b0;
  endtask

  // write: pointer byte then n data bytes from wbuf; optional STOP
  task automatic do_write(input logic [6:0] a7, input logic [7:0] ptrb, input int n,
                          input bit match, input bit with_stop);
    bit ack;
    bus_start();
    send_byte({a7, 1'b0}, ack);
    check(ack == match, match ? "R1 address ack" : "R2 mismatch no ack", 64'(ack), 64'(match));
    send_byte(ptrb, ack);
    check(ack == match, "R6 pointer byte ack", 64'(ack), 64'(match));
    if (match) begin m_auto = ptrb[7]; m_idx = ptrb[6:0]; end
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check(ack == match, "R6 data byte ack", 64'(ack), 64'(match));
      if (match) begin mwrite(m_idx, wbuf[i]); madv(); end
    end
    if (with_stop) bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a7, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte({a7, 1'b1}, ack);
    check(ack, "R1 read address ack", 64'(ack), 64'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      check(b == exp_rd(m_idx), tag, 64'(b), 64'(exp_rd(m_idx)));
      madv();
    end
    wq(1);
    check(sda_bus == 1'b1, "R8 released after NACK", 64'(sda_bus), 64'd1);
    bus_stop();
  endtask

  function automatic logic [6:0] addr(input logic lsb);
    return {6'b001000, lsb};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    m_auto = 1'b0; m_idx = 7'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    check(regs_flat == exp_flat(), "R12 reset contents", regs_flat, exp_flat());
    check(sda_oe == 1'b0, "R12 line released", 64'(sda_oe), 64'd0);
    do_read(addr(1'b0), 2, "R12 read after reset pointer 0 no auto");

    // R3/R5: block write with auto-increment across wrap 7 -> 0
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(addr(1'b0), 8'h87, 3, 1'b1, 1'b1);
    check(regs_flat == exp_flat(), "R5 wrap write contents", regs_flat, exp_flat());

    // R9: set pointer then repeated START read, pointer kept
    do_write(addr(1'b0), 8'h87, 0, 1'b1, 1'b0);
    do_read(addr(1'b0), 3, "R9 repeated start read with wrap R4");

    // R7: read-only register and bits
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    do_write(addr(1'b0), 8'h01, 1, 1'b1, 1'b1);
    do_write(addr(1'b0), 8'h06, 1, 1'b1, 1'b1);
    check(regs_flat == exp_flat(), "R7 read-only bits kept", regs_flat, exp_flat());
    do_write(addr(1'b0), 8'h81, 0, 1'b1, 1'b0);
    do_read(addr(1'b0), 6, "R7 read-only readback");

    // R11: out-of-range index
    wbuf[0] = 8'h5A;
    do_write(addr(1'b0), 8'h0A, 1, 1'b1, 1'b0);
    do_read(addr(1'b0), 1, "R11 out-of-range reads zero");
    check(regs_flat == exp_flat(), "R11 out-of-range write ignored", regs_flat, exp_flat());

    // R2: wrong strap bit and wrong prefix are ignored
    wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
    do_write(addr(1'b1), 8'h82, 2, 1'b0, 1'b1);
    check(regs_flat == exp_flat(), "R2 strap mismatch no change", regs_flat, exp_flat());
    do_write(7'b0101000, 8'h80, 2, 1'b0, 1'b1);
    check(regs_flat == exp_flat(), "R2 prefix mismatch no change", regs_flat, exp_flat());

    // R1: strap high selects the other address
    strap = 1'b1;
    wbuf[0] = 8'h3C;
    do_write(addr(1'b1), 8'h03, 1, 1'b1, 1'b1);
    check(regs_flat == exp_flat(), "R1 strap high write", regs_flat, exp_flat());
    do_write(addr(1'b0), 8'h83, 1, 1'b0, 1'b1);
    check(regs_flat == exp_flat(), "R2 old address now ignored", regs_flat, exp_flat());

    // random transactions
    for (int t = 0; t < 40; t++) begin
      logic [7:0] p;
      int nw, nr;
      p = {1'($urandom), 4'b0000, 3'($urandom)};
      if ($urandom % 8 == 0) p[6:0] = 7'(8 + $urandom % 20);
      nw = $urandom % 4;
      for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
      do_write(addr(1'b1), p, nw, 1'b1, 1'b1);
      check(regs_flat == exp_flat(), "R3 random write contents", regs_flat, exp_flat());
      nr = 1 + $urandom % 3;
      if ($urandom % 2 == 1) do_write(addr(1'b1), p, 0, 1'b1, 1'b0);
      do_read(addr(1'b1), nr, "R4 random read R5");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule